// File: doc/BRIEF.md
# Jitter Buffer Fill Governor with Three-Step Resample Ratio

This block sits beside a sample jitter buffer that links a producer and a consumer running from unrelated clocks. It does not hold or move samples. Instead it keeps a running count of how many samples the buffer holds, raises a low and a high flag against two thresholds, and holds back playout until the buffer is half full.

The consumer always takes output blocks of a fixed size. For each output block the block tells the resampler how many input samples to use for that block. The choice is one of three counts. Taking fewer samples lets a draining buffer refill, taking more drains a buffer that is filling up, and the nominal count leaves the level where it is. The choice is made when each output block completes and then held until the next one. The capacity, the two thresholds and the prefill level are loaded from configuration pins while reset is held.

Top module: `fill_ratio_governor`

## Requirements
- R1: While `rst_n` is low, the block loads the configuration pins into its registers. After reset, `level` is 0, `play_en` is 0, both error flags are 0 and `in_count` is the nominal count (128). Configuration pins that change after reset has been released have no effect.
- R2: Each `wr_blk` strobe adds the block size (128) to `level`. The new value appears one clock after the strobe.
- R3: While `play_en` is 1, each `rd_blk` strobe subtracts from `level` the `in_count` value that was presented during that strobe.
- R4: While `play_en` is 0, `rd_blk` strobes leave `level` and `in_count` unchanged.
- R5: `play_en` goes to 1 in the same clock edge that `level` becomes equal to or greater than the prefill value. It then stays at 1 until the next reset.
- R6: `low_flag` is 1 exactly when `level` is below the low threshold. `high_flag` is 1 exactly when `level` is above the high threshold.
- R7: On each accepted read, `in_count` is set from the new level. It is 115 when the new level is below the low threshold, 141 when the new level is above the high threshold, and 128 otherwise. Between accepted reads, `in_count` holds its value.
- R8: If an update would push `level` above the capacity, `level` is clamped to the capacity. `ovf_err` is then set and stays at 1 until reset.
- R9: If an update would push `level` below zero, `level` is clamped to 0. `unf_err` is then set and stays at 1 until reset.
- R10: When a write and an accepted read fall in the same clock, both take effect together: `level` changes by 128 minus the granted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is loaded while it is low |
| cfg_capacity | input | 12 | Buffer capacity in samples |
| cfg_low_wm | input | 12 | Low threshold in samples |
| cfg_high_wm | input | 12 | High threshold in samples |
| cfg_prefill | input | 12 | Level at which playout begins |
| wr_blk | input | 1 | Producer has written one block |
| rd_blk | input | 1 | Consumer has taken one output block |
| level | output | 12 | Current fill level in samples |
| low_flag | output | 1 | Level is below the low threshold |
| high_flag | output | 1 | Level is above the high threshold |
| play_en | output | 1 | Playout is allowed |
| in_count | output | 9 | Input samples to consume for the current output block |
| ovf_err | output | 1 | Sticky flag: the level was clamped at capacity |
| unf_err | output | 1 | Sticky flag: the level was clamped at zero |

## Verification
If the internal level drifts from the true count, the error shows at the ports on the next clock edge. It appears as a wrong `level`, and both flags are derived from `level` without a register. A wrong ratio decision cannot be seen until the read strobe that latches it: from then on `in_count` is off, and the next accepted read subtracts the wrong amount. A playout gate that releases too early is exposed by the first read before prefill, because that read then changes `level` on the following edge.

// File: rtl/fill_ratio_pkg.sv
package fill_ratio_pkg;
   typedef enum logic [1:0] {
      RATIO_SLOW = 2'd0,
      RATIO_NOM  = 2'd1,
      RATIO_FAST = 2'd2
   } ratio_e;
endpackage

// File: rtl/fill_tracker.sv
module fill_tracker #(
   parameter int LVL_W = 12,
   parameter int BLK   = 128,
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] cap,
   input  logic             wr_blk,
   input  logic             rd_take,
   input  logic [CNT_W-1:0] take_cnt,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] level_nxt,
   output logic             ovf_err,
   output logic             unf_err
);
   localparam int SW = LVL_W + 2;
   localparam logic [SW-1:0] BLK_V = SW'(BLK);

   logic [SW-1:0] add_v, sub_v, sum;
   logic          neg, over;

   always_comb begin
      add_v = wr_blk  ? BLK_V : '0;
      sub_v = rd_take ? {{(SW-CNT_W){1'b0}}, take_cnt} : '0;
      sum   = {2'b00, level} + add_v - sub_v;
      neg   = sum[SW-1];
      over  = !neg && (sum[LVL_W:0] > {1'b0, cap});
      if (neg)
         level_nxt = '0;
      else if (over)
         level_nxt = cap;
      else
         level_nxt = sum[LVL_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level   <= '0;
         ovf_err <= 1'b0;
         unf_err <= 1'b0;
      end else begin
         level <= level_nxt;
         if (over) ovf_err <= 1'b1;
         if (neg)  unf_err <= 1'b1;
      end
   end
endmodule

// File: rtl/ratio_picker.sv
module ratio_picker
   import fill_ratio_pkg::*;
#(
   parameter int LVL_W         = 12,
   parameter int BLK           = 128,
   parameter int CNT_W         = 9,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_take,
   input  logic [LVL_W-1:0] level_nxt,
   input  logic [LVL_W-1:0] low_wm,
   input  logic [LVL_W-1:0] high_wm,
   output logic [CNT_W-1:0] in_count
);
   localparam int RND      = ROUND_NEAREST ? 5 : 0;
   localparam int CNT_SLOW = (BLK * 9 + RND) / 10;
   localparam int CNT_FAST = (BLK * 11 + RND) / 10;

   ratio_e sel;

   always_comb begin
      if (level_nxt < low_wm)
         sel = RATIO_SLOW;
      else if (level_nxt > high_wm)
         sel = RATIO_FAST;
      else
         sel = RATIO_NOM;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         in_count <= CNT_W'(BLK);
      else if (rd_take) begin
         unique case (sel)
            RATIO_SLOW: in_count <= CNT_W'(CNT_SLOW);
            RATIO_FAST: in_count <= CNT_W'(CNT_FAST);
            default:    in_count <= CNT_W'(BLK);
         endcase
      end
   end
endmodule

// File: rtl/prefill_gate.sv
module prefill_gate #(
   parameter int LVL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_nxt,
   input  logic [LVL_W-1:0] prefill,
   output logic             play_en
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         play_en <= 1'b0;
      else if (level_nxt >= prefill)
         play_en <= 1'b1;
   end
endmodule

// File: rtl/fill_ratio_governor.sv
module fill_ratio_governor #(
   parameter int LVL_W         = 12,
   parameter int BLK           = 128,
   parameter bit ROUND_NEAREST = 1'b1,
   localparam int CNT_W        = $clog2(2 * BLK + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] cfg_capacity,
   input  logic [LVL_W-1:0] cfg_low_wm,
   input  logic [LVL_W-1:0] cfg_high_wm,
   input  logic [LVL_W-1:0] cfg_prefill,
   input  logic             wr_blk,
   input  logic             rd_blk,
   output logic [LVL_W-1:0] level,
   output logic             low_flag,
   output logic             high_flag,
   output logic             play_en,
   output logic [CNT_W-1:0] in_count,
   output logic             ovf_err,
   output logic             unf_err
);
   generate
      if (BLK < 10) begin : g_bad_blk
         $error("BLK must be at least 10");
      end
      if (CNT_W > LVL_W + 2) begin : g_bad_width
         $error("LVL_W too narrow for the block count");
      end
      if ((1 << LVL_W) <= BLK) begin : g_bad_level
         $error("LVL_W cannot hold one block");
      end
   endgenerate

   logic [LVL_W-1:0] cap_q, low_q, high_q, pre_q, level_nxt;
   logic             rd_take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q  <= cfg_capacity;
         low_q  <= cfg_low_wm;
         high_q <= cfg_high_wm;
         pre_q  <= cfg_prefill;
      end
   end

   assign rd_take   = rd_blk && play_en;
   assign low_flag  = level < low_q;
   assign high_flag = level > high_q;

   fill_tracker #(.LVL_W(LVL_W), .BLK(BLK), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .cap(cap_q), .wr_blk(wr_blk),
      .rd_take(rd_take), .take_cnt(in_count), .level(level),
      .level_nxt(level_nxt), .ovf_err(ovf_err), .unf_err(unf_err)
   );

   ratio_picker #(.LVL_W(LVL_W), .BLK(BLK), .CNT_W(CNT_W),
                  .ROUND_NEAREST(ROUND_NEAREST)) u_pick (
      .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .level_nxt(level_nxt),
      .low_wm(low_q), .high_wm(high_q), .in_count(in_count)
   );

   prefill_gate #(.LVL_W(LVL_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .level_nxt(level_nxt),
      .prefill(pre_q), .play_en(play_en)
   );
endmodule

// File: rtl/fill_ratio_governor_chk.sv
module fill_ratio_governor_chk #(
   parameter int LVL_W = 12,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_blk,
   input logic             rd_blk,
   input logic [LVL_W-1:0] level,
   input logic [LVL_W-1:0] cap_q,
   input logic             play_en,
   input logic [CNT_W-1:0] in_count,
   input logic             ovf_err,
   input logic             unf_err
);
   a_r8_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      level <= cap_q);
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);
   a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err |=> unf_err);
   a_r5_play_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      play_en |=> play_en);
   a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_blk |=> $stable(in_count));
   a_r7_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_count == 115) || (in_count == 128) || (in_count == 141));
   a_r4_no_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!play_en && !wr_blk) |=> $stable(level));
endmodule

bind fill_ratio_governor fill_ratio_governor_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_blk(wr_blk), .rd_blk(rd_blk),
   .level(level), .cap_q(cap_q), .play_en(play_en), .in_count(in_count),
   .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/fill_ratio_governor_test.sv
module fill_ratio_governor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_capacity, cfg_low_wm, cfg_high_wm, cfg_prefill;
   logic        wr_blk = 1'b0, rd_blk = 1'b0;
   logic [11:0] level;
   logic        low_flag, high_flag, play_en, ovf_err, unf_err;
   logic [8:0]  in_count;

   int n_chk = 0, n_bad = 0;
   int m_lvl, m_cnt, m_cap, m_low, m_high, m_pre;
   bit m_play, m_ovf, m_unf;

   always #10 clk = ~clk;

   fill_ratio_governor uut (
      .clk(clk), .rst_n(rst_n), .cfg_capacity(cfg_capacity),
      .cfg_low_wm(cfg_low_wm), .cfg_high_wm(cfg_high_wm),
      .cfg_prefill(cfg_prefill), .wr_blk(wr_blk), .rd_blk(rd_blk),
      .level(level), .low_flag(low_flag), .high_flag(high_flag),
      .play_en(play_en), .in_count(in_count), .ovf_err(ovf_err),
      .unf_err(unf_err)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "level", level, m_lvl);
      chk(tag, "low_flag", low_flag, m_lvl < m_low);
      chk(tag, "high_flag", high_flag, m_lvl > m_high);
      chk(tag, "play_en", play_en, m_play);
      chk(tag, "in_count", in_count, m_cnt);
      chk(tag, "ovf_err", ovf_err, m_ovf);
      chk(tag, "unf_err", unf_err, m_unf);
   endtask

   task automatic do_reset(int cap, int lo, int hi, int pre);
      @(negedge clk);
      cfg_capacity = 12'(cap); cfg_low_wm = 12'(lo);
      cfg_high_wm = 12'(hi); cfg_prefill = 12'(pre);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_cap = cap; m_low = lo; m_high = hi; m_pre = pre;
      m_lvl = 0; m_cnt = 128; m_play = 0; m_ovf = 0; m_unf = 0;
      // R1: change the pins after release; they must not matter
      cfg_capacity = 12'd100; cfg_low_wm = 12'd0;
      cfg_high_wm = 12'd4000; cfg_prefill = 12'd1;
   endtask

   task automatic step(bit w, bit r, string tag);
      int s;
      bit take;
      @(negedge clk);
      wr_blk = w; rd_blk = r;
      @(negedge clk);
      wr_blk = 1'b0; rd_blk = 1'b0;
      take = r && m_play;
      s = m_lvl + (w ? 128 : 0) - (take ? m_cnt : 0);
      if (s < 0) begin s = 0; m_unf = 1; end
      else if (s > m_cap) begin s = m_cap; m_ovf = 1; end
      m_lvl = s;
      if (m_lvl >= m_pre) m_play = 1;
      if (take) m_cnt = (m_lvl < m_low) ? 115 : (m_lvl > m_high) ? 141 : 128;
      check_all(tag);
   endtask

   task automatic t_reset();
      do_reset(1280, 256, 1024, 640);
      @(negedge clk);
      check_all("R1");
   endtask

   task automatic t_prefill();
      step(0, 1, "R4");
      for (int i = 0; i < 4; i++) step(1, 0, "R2");
      chk("R5", "play before prefill", play_en, 0);
      step(1, 0, "R5");
      chk("R5", "play at prefill", play_en, 1);
   endtask

   task automatic t_ratio();
      for (int i = 0; i < 5; i++) step(0, 1, "R3");
      chk("R7", "slow count", in_count, 115);
      chk("R6", "low flag", low_flag, 1);
      for (int i = 0; i < 8; i++) step(1, 0, "R6");
      chk("R6", "high flag", high_flag, 1);
      step(0, 1, "R7");
      step(1, 0, "R2");
      step(1, 0, "R2");
      step(1, 0, "R8");
      chk("R8", "level clamped", level, 1280);
      step(0, 1, "R7");
      chk("R7", "fast count", in_count, 141);
      step(0, 1, "R3");
      step(1, 0, "R8");
   endtask

   task automatic t_both();
      step(1, 1, "R10");
      step(1, 1, "R10");
   endtask

   task automatic t_underflow();
      for (int i = 0; i < 12; i++) step(0, 1, "R9");
      chk("R9", "level at zero", level, 0);
      chk("R9", "unf sticky", unf_err, 1);
   endtask

   task automatic t_second_cfg();
      do_reset(640, 128, 512, 256);
      @(negedge clk);
      check_all("R1");
      step(1, 0, "R5");
      step(1, 0, "R5");
      for (int i = 0; i < 4; i++) step(1, 0, "R6");
      step(0, 1, "R7");
      step(1, 0, "R8");
   endtask

   initial begin
      cfg_capacity = '0; cfg_low_wm = '0; cfg_high_wm = '0; cfg_prefill = '0;
      t_reset();
      t_prefill();
      t_ratio();
      t_both();
      t_underflow();
      t_second_cfg();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule